// File: doc/BRIEF.md
# RTC Calibration Prescaler

This block sits between a 32.768 kHz crystal tick and the seconds counter of a real-time clock. It counts ticks into a prescaler and emits a single-cycle enable each time the prescaler wraps, which gives a 1 Hz timekeeping strobe. To trim out crystal error, it can add or drop prescaler counts at a fixed rate. A signed calibration code sets that rate. Sign 1 inserts counts for a slow crystal. Sign 0 swallows counts for a fast crystal. The magnitude gives how many counts are adjusted per correction window, about 4.34 ppm per step with the default window.

Software uses a small write port. It first sets a calibration-mode bit. While that bit is set, a shared output pin carries a measurement tone derived from the raw, uncorrected tick count, and the calibration code may be written. With the bit clear, the pin passes an external power-fail signal through and writes to the code are dropped. The mode bit and the code are brought out as outputs so the surrounding logic can read them.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: After a synchronous active-low reset, cal_mode is 0, cal_code is 000000, sec_pulse is 0 and all tick counters start from zero.
- R2: A write with wr_addr = 0 loads wr_data bit 0 into cal_mode on the next clock edge. 1 enters calibration mode and 0 leaves it.
- R3: A write with wr_addr = 1 loads wr_data[5:0] into cal_code only if cal_mode is 1 at that edge. Otherwise cal_code keeps its value. Bit 5 of the code is the sign and bits 4..0 are the magnitude.
- R4: While cal_mode is 0, cal_pfo follows pwr_fail.
- R5: While cal_mode is 1, cal_pfo is a square wave of the raw tick count with a period of 2^TONE_SHIFT ticks. It is high when bit TONE_SHIFT-1 of the raw count is 1, so with the default of 6 it runs at 512 Hz.
- R6: sec_pulse is high for exactly one cycle, in the cycle after the tick that carries the corrected prescaler past 2^DIV_BITS. With no correction this happens once every 2^DIV_BITS ticks.
- R7: With sign 1 and magnitude m > 0, the first m ticks of each window advance the prescaler by 2 instead of 1.
- R8: With sign 0 and magnitude m > 0, the first m ticks of each window leave the prescaler unchanged.
- R9: A magnitude of 0 gives no correction, whatever the sign bit.
- R10: A correction window is exactly WINDOW ticks long and repeats without gaps from reset. Each window applies exactly m adjustments.
- R11: Cycles without tick_32k advance no counter and raise no sec_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe per crystal period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control bit, 1 = calibration code |
| wr_data | input | 8 | Write data |
| pwr_fail | input | 1 | Power-fail signal passed to the shared pin |
| cal_pfo | output | 1 | Shared pin: tone in calibration mode, else power-fail |
| sec_pulse | output | 1 | One-cycle 1 Hz timekeeping enable |
| cal_mode | output | 1 | Current calibration-mode bit |
| cal_code | output | 6 | Current calibration code (sign, magnitude) |

## Verification
The assertions assume tick_32k is a strobe, which the default division of 2^15 makes safe: no two wraps can land on adjacent ticks. They also assume at most one register write per cycle, which the port shape enforces. The stimulus uses a bench-sized prescaler of 2^8 and a window of 64, which is larger than the largest magnitude of 31. It drives writes only while ticks are idle, so the count-based checks start from zeroed counters. It then mixes gapped ticks, pin toggles and mode changes while the reference model tracks every cycle.

// File: rtl/rtcp_pkg.sv
// Shared types for the RTC calibration prescaler.
// Assumes a 6-bit calibration code: one sign bit above a 5-bit magnitude.
package rtcp_pkg;
    localparam int MAG_W  = 5;
    localparam int CODE_W = MAG_W + 1;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_CAL  = 1'b1;

    typedef struct packed {
        logic             add;   // 1: insert counts (slow clock), 0: swallow
        logic [MAG_W-1:0] mag;   // adjustments per window
    } cal_code_t;

    typedef enum logic [1:0] {
        STEP_NORMAL  = 2'd0,
        STEP_INSERT  = 2'd1,
        STEP_SWALLOW = 2'd2
    } step_e;
endpackage

// File: rtl/rtcp_regs.sv
// Control bit and calibration code behind a one-bit-address write port.
// The code is write-protected unless the mode bit is already set at the
// edge of the write. Assumes at most one write per cycle.
module rtcp_regs
    import rtcp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      wr_addr,
    input  logic [7:0] wr_data,
    output logic      mode_q,
    output cal_code_t code_q
);
    // Mode bit: loaded from data bit 0 on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            mode_q <= wr_data[0];
        end
    end

    // Calibration code: accepted only while calibration mode is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (wr_en && wr_addr == ADDR_CAL && mode_q) begin
            code_q <= cal_code_t'(wr_data[CODE_W-1:0]);
        end
    end
endmodule

// File: rtl/rtcp_trim.sv
// Correction scheduler. Counts ticks in windows of WINDOW and marks the
// first 'mag' ticks of each window as insert or swallow steps.
// Assumes WINDOW exceeds the largest magnitude (2^MAG_W - 1).
module rtcp_trim
    import rtcp_pkg::*;
#(
    parameter int WINDOW = 230400
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  cal_code_t code,
    output step_e     step
);
    localparam int WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);

    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] mag_ext;
    logic             in_adjust;

    assign mag_ext   = WIN_W'(code.mag);
    assign in_adjust = (win_q < mag_ext);

    // Window position: advances on each tick, wraps after WINDOW ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (tick) begin
            win_q <= (win_q == WIN_LAST) ? '0 : win_q + 1'b1;
        end
    end

    // Step kind for the current tick, chosen from sign and window position.
    always_comb begin
        if (!in_adjust) begin
            step = STEP_NORMAL;
        end else if (code.add) begin
            step = STEP_INSERT;
        end else begin
            step = STEP_SWALLOW;
        end
    end
endmodule

// File: rtl/rtcp_prescaler.sv
// Corrected prescaler. Adds 0, 1 or 2 per tick according to the step
// kind and raises a one-cycle pulse when the sum carries out of DIV_BITS.
// Assumes DIV_BITS >= 2, so two wraps cannot follow on adjacent ticks.
module rtcp_prescaler
    import rtcp_pkg::*;
#(
    parameter int DIV_BITS = 15
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  step_e step,
    output logic  wrap_pulse
);
    logic [DIV_BITS-1:0] cnt_q;
    logic [DIV_BITS:0]   sum;
    logic [1:0]          incr;

    // Increment per tick: doubled on insert, zero on swallow.
    always_comb begin
        case (step)
            STEP_INSERT:  incr = 2'd2;
            STEP_SWALLOW: incr = 2'd0;
            default:      incr = 2'd1;
        endcase
        sum = {1'b0, cnt_q} + {{(DIV_BITS-1){1'b0}}, incr};
    end

    // Count register and wrap strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            wrap_pulse <= 1'b0;
        end else begin
            wrap_pulse <= tick && sum[DIV_BITS];
            if (tick) begin
                cnt_q <= sum[DIV_BITS-1:0];
            end
        end
    end
endmodule

// File: rtl/rtcp_tone.sv
// Measurement tone from the uncorrected tick count. Divides by
// 2^TONE_SHIFT with 50% duty. Assumes TONE_SHIFT >= 1.
module rtcp_tone #(
    parameter int TONE_SHIFT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic tone
);
    logic [TONE_SHIFT-1:0] raw_q;

    // Raw tick counter, free of any correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else if (tick) begin
            raw_q <= raw_q + 1'b1;
        end
    end

    assign tone = raw_q[TONE_SHIFT-1];
endmodule

// File: rtl/rtc_cal_prescaler.sv
// Top of the RTC calibration prescaler. Divides the crystal tick to a
// 1 Hz enable with sign-magnitude trim, and shares one pin between the
// measurement tone and power-fail. Assumes tick_32k is a synchronous
// one-cycle strobe and pwr_fail is already synchronised.
module rtc_cal_prescaler
    import rtcp_pkg::*;
#(
    parameter int DIV_BITS   = 15,
    parameter int TONE_SHIFT = 6,
    parameter int WINDOW     = 230400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       pwr_fail,
    output logic       cal_pfo,
    output logic       sec_pulse,
    output logic       cal_mode,
    output logic [5:0] cal_code
);
    cal_code_t code_q;
    step_e     step;
    logic      tone;

    rtcp_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mode_q  (cal_mode),
        .code_q  (code_q)
    );

    rtcp_trim #(.WINDOW(WINDOW)) u_trim (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_32k),
        .code  (code_q),
        .step  (step)
    );

    rtcp_prescaler #(.DIV_BITS(DIV_BITS)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_32k),
        .step       (step),
        .wrap_pulse (sec_pulse)
    );

    rtcp_tone #(.TONE_SHIFT(TONE_SHIFT)) u_tone (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_32k),
        .tone  (tone)
    );

    // Shared pin: tone during calibration, otherwise power-fail.
    assign cal_pfo  = cal_mode ? tone : pwr_fail;
    assign cal_code = code_q;
endmodule

// File: rtl/rtc_cal_prescaler_chk.sv
// Property checker for rtc_cal_prescaler, attached by bind below.
module rtc_cal_prescaler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_32k,
    input logic       wr_en,
    input logic       wr_addr,
    input logic [7:0] wr_data,
    input logic       cal_pfo,
    input logic       sec_pulse,
    input logic       cal_mode,
    input logic [5:0] cal_code
);
    logic rst_seen_q;

    // Remembers that reset was applied at the previous edge.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_state_R1: assert (!cal_mode && cal_code == 6'd0 && !sec_pulse)
                else $error("reset state wrong");
        end
    end

    assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 1'b0) |=> (cal_mode == $past(wr_data[0])));

    assert_code_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 1'b1 && !cal_mode) |=> $stable(cal_code));

    assert_code_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 1'b1 && cal_mode) |=> (cal_code == $past(wr_data[5:0])));

    assert_tone_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_mode && !tick_32k && !wr_en) |=> $stable(cal_pfo));

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> !sec_pulse);

    assert_pulse_needs_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_32k |=> !sec_pulse);
endmodule

bind rtc_cal_prescaler rtc_cal_prescaler_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_32k  (tick_32k),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cal_pfo   (cal_pfo),
    .sec_pulse (sec_pulse),
    .cal_mode  (cal_mode),
    .cal_code  (cal_code)
);

// File: tb/rtc_cal_prescaler_tb.sv
`timescale 1ns/1ps
module rtc_cal_prescaler_tb;
    localparam int DB  = 8;
    localparam int TS  = 6;
    localparam int WIN = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       pwr_fail = 1'b0;
    logic       cal_pfo, sec_pulse, cal_mode;
    logic [5:0] cal_code;

    int n_chk = 0;
    int n_fail = 0;
    int pulse_cnt = 0;
    bit cmp_en = 0;
    bit done = 0;

    int m_presc = 0, m_raw = 0, m_win = 0, m_mode = 0, m_code = 0, m_sec = 0;

    always #2 clk = ~clk;

    rtc_cal_prescaler #(.DIV_BITS(DB), .TONE_SHIFT(TS), .WINDOW(WIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwr_fail(pwr_fail),
        .cal_pfo(cal_pfo), .sec_pulse(sec_pulse), .cal_mode(cal_mode),
        .cal_code(cal_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated at each rising edge.
    always @(posedge clk) begin : model
        int step, sum, mag;
        if (!rst_n) begin
            m_presc = 0; m_raw = 0; m_win = 0; m_mode = 0; m_code = 0; m_sec = 0;
        end else begin
            m_sec = 0;
            mag = m_code % 32;
            if (tick) begin
                m_raw = (m_raw + 1) % (1 << TS);
                step = 1;
                if (m_win < mag) step = (m_code >= 32) ? 2 : 0;
                sum = m_presc + step;
                m_sec = (sum >= (1 << DB)) ? 1 : 0;
                m_presc = sum % (1 << DB);
                m_win = (m_win + 1) % WIN;
            end
            if (wr_en) begin
                if (wr_addr == 1'b0) m_mode = int'(wr_data[0]);
                else if (m_mode == 1) m_code = int'(wr_data[5:0]);
            end
        end
        if (sec_pulse) pulse_cnt++;
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_en && rst_n && !done) begin
            int exp_pfo;
            exp_pfo = (m_mode == 1) ? ((m_raw >> (TS - 1)) & 1) : int'(pwr_fail);
            check(int'(sec_pulse) == m_sec, "R6 sec_pulse per cycle", int'(sec_pulse), m_sec);
            check(int'(cal_mode) == m_mode, "R2 cal_mode per cycle", int'(cal_mode), m_mode);
            check(int'(cal_code) == m_code, "R3 cal_code per cycle", int'(cal_code), m_code);
            if (m_mode == 1)
                check(int'(cal_pfo) == exp_pfo, "R5 tone per cycle", int'(cal_pfo), exp_pfo);
            else
                check(int'(cal_pfo) == exp_pfo, "R4 pass-through per cycle", int'(cal_pfo), exp_pfo);
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic do_write(input logic addr, input logic [7:0] data);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(posedge clk); #1;
            tick = 1'b0;
            repeat (gap) begin @(posedge clk); #1; end
        end
    endtask

    task automatic count_seconds(input int n, output int got);
        int c0;
        c0 = pulse_cnt;
        run_ticks(n, 0);
        repeat (3) begin @(posedge clk); #1; end
        got = pulse_cnt - c0;
    endtask

    task automatic trim_case(input logic [5:0] code, input int exp, input string req);
        int got;
        do_reset();
        do_write(1'b0, 8'h01);
        do_write(1'b1, {2'b00, code});
        count_seconds(4096, got);
        check(got == exp, req, got, exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int got;
        @(posedge clk); #1;
        do_reset();
        cmp_en = 1;
        // R1: reset state
        check(cal_mode == 1'b0 && cal_code == 6'd0 && sec_pulse == 1'b0,
              "R1 reset state", {cal_mode, cal_code}, 0);
        // R3: write ignored while mode is off
        do_write(1'b1, 8'h25);
        check(cal_code == 6'd0, "R3 locked write ignored", cal_code, 0);
        // R2: enter mode
        do_write(1'b0, 8'h01);
        check(cal_mode == 1'b1, "R2 mode set", cal_mode, 1);
        do_write(1'b1, 8'h25);
        check(cal_code == 6'h25, "R3 write accepted", cal_code, 6'h25);
        // R5: tone goes high after half a period, low after a full period
        run_ticks(32, 0);
        check(cal_pfo == 1'b1, "R5 tone high half period", cal_pfo, 1);
        run_ticks(32, 0);
        check(cal_pfo == 1'b0, "R5 tone low full period", cal_pfo, 0);
        // R7, R8, R9, R10, R6: second counts over 64 windows
        trim_case(6'h25, (4096 + 5 * 64) / 256, "R7 insert count");
        trim_case(6'h05, (4096 - 5 * 64) / 256, "R8 swallow count");
        trim_case(6'h20, 4096 / 256, "R9 sign without magnitude");
        trim_case(6'h00, 4096 / 256, "R6 uncorrected count");
        trim_case(6'h1F, (4096 - 31 * 64) / 256, "R10 full magnitude per window");
        trim_case(6'h3F, (4096 + 31 * 64) / 256, "R10 full insert per window");
        // R4: pass-through with mode off, gapped ticks
        do_reset();
        pwr_fail = 1'b1; #1;
        check(cal_pfo == 1'b1, "R4 pin follows high", cal_pfo, 1);
        run_ticks(300, 2);
        pwr_fail = 1'b0; #1;
        check(cal_pfo == 1'b0, "R4 pin follows low", cal_pfo, 0);
        // R11: idle cycles raise no pulse
        got = pulse_cnt;
        repeat (600) begin @(posedge clk); #1; end
        check(pulse_cnt == got, "R11 no pulse without ticks", pulse_cnt - got, 0);
        // R3: code locked again after leaving mode
        do_write(1'b0, 8'h01);
        do_write(1'b1, 8'h2A);
        do_write(1'b0, 8'h00);
        check(cal_mode == 1'b0, "R2 mode cleared", cal_mode, 0);
        do_write(1'b1, 8'h11);
        check(cal_code == 6'h2A, "R3 locked after exit", cal_code, 6'h2A);
        // Mixed traffic with mode on and gapped ticks
        do_write(1'b0, 8'h01);
        for (int k = 0; k < 8; k++) begin
            run_ticks(200, k % 3);
            pwr_fail = ~pwr_fail;
            do_write(1'b1, 8'(k * 9));
        end
        repeat (4) begin @(posedge clk); #1; end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule